// File: doc/BRIEF.md
# Slow-Control Command Frame Parser

This block sits on the slave side of a half-duplex serial slow-control link. A byte-level serial receiver outside the block hands it one byte at a time, each with a one-cycle valid strobe. The parser hunts for the start marker of a fixed-length command frame. It tracks each byte's position in the frame and keeps only frames sent to this slave's address. From those frames it collects a firmware identifier, a command byte and five 16-bit converter setpoints. A running CRC is checked against the final byte.

A frame whose CRC matches updates every collected field on the same clock edge and raises a one-cycle accept pulse. A CRC mismatch raises a one-cycle reject pulse, leaves the fields alone and bumps a saturating failure counter. A frame that stalls for too long between bytes is dropped, and the parser goes back to hunting. The idle limit comes from an input, so the same block can follow links of different speeds. At 250000 baud from a 50 MHz clock, one bit lasts 200 cycles, so a byte takes about 2000 cycles.

Top module: `sc_frame_rx`

## Requirements
- R1: A synchronous active-high `rst` clears both pulses, `fw_id`, `cmd_code`, `dac_set` and `crc_fail_count` to zero, and puts the parser in hunt mode.
- R2: In hunt mode, any byte other than 0x40 is discarded. A 0x40 becomes byte 0 of a new frame. Inside a frame, 0x40 is ordinary data.
- R3: A frame is exactly 28 bytes, positions 0 to 27. If byte 1 is not 0x3F, bytes up to position 27 are still consumed, but nothing is captured, no pulse is raised and the counter does not move.
- R4: Byte 3 goes to `fw_id` and byte 4 to `cmd_code`. Setpoint k (k = 0..4) is sent as byte 5+2k (low half) and then byte 6+2k (high half), and it appears on `dac_set[16k+15:16k]`. Byte 2, bytes 15 to 25 and byte 26 are not checked.
- R5: The check value is a CRC-8 over bytes 0 to 26, with polynomial 0x07, initial value 0x00, MSB first, no reflection and no final XOR. The frame is good only if the CRC equals byte 27.
- R6: For a good frame addressed to this slave, all fields change on the clock edge that samples byte 27. `frame_ok` is high for exactly the following cycle, and the fields change at no other time.
- R7: On a CRC mismatch, `frame_err` is high for one cycle, the fields keep their values, and `crc_fail_count` goes up by one on the same edge. The counter saturates at 255.
- R8: Inside a frame, up to `gap_limit` consecutive idle cycles between strobes are tolerated. On idle cycle `gap_limit`+1 the frame is dropped with no pulse, and the next byte is handled in hunt mode.
- R9: `frame_ok` and `frame_err` are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| gap_limit | input | GAP_W (16) | Idle cycles allowed between bytes inside a frame |
| fw_id | output | 8 | Firmware identifier of the last good frame |
| cmd_code | output | 8 | Command code of the last good frame |
| dac_set | output | 80 | Five 16-bit setpoints, setpoint k at bits 16k+15:16k |
| frame_ok | output | 1 | One-cycle pulse: good frame taken |
| frame_err | output | 1 | One-cycle pulse: CRC mismatch |
| crc_fail_count | output | ERR_W (8) | Saturating count of CRC mismatches |

## Verification
The hardest cases to reach from the ports are the boundary of the idle timeout and the counter's saturation. For the timeout, the stimulus places a gap of exactly `gap_limit` idle cycles inside one frame and `gap_limit`+1 inside another. It then leaves a long quiet period, so that any stray 0x40 among the leftover bytes cannot start a frame that runs into the next test. For saturation, more than 255 frames with corrupted CRCs are sent back to back, and then a good frame shows that accept still works with the counter pinned. A behavioural model holds the frame bytes in a queue and is compared with every output on every clock.

// File: rtl/sc_frame_pkg.sv
package sc_frame_pkg;
    localparam int FRAME_LEN = 28;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int N_DAC     = 5;
    localparam int DAC_W     = 16;
    localparam int DAC_BITS  = N_DAC * DAC_W;
    localparam int POS_DAC0  = 5;

    typedef logic [POS_W-1:0] pos_t;

    localparam logic [7:0] SOF_BYTE = 8'h40;
    localparam logic [7:0] MY_ADDR  = 8'h3F;
    localparam logic [7:0] CRC_POLY = 8'h07;
    localparam pos_t POS_ADDR = pos_t'(1);
    localparam pos_t POS_FW   = pos_t'(3);
    localparam pos_t POS_CMD  = pos_t'(4);
    localparam pos_t POS_LAST = pos_t'(FRAME_LEN - 1);

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_TAKE = 2'd1,
        ST_PASS = 2'd2
    } rx_state_e;
endpackage

// File: rtl/sc_crc8_step.sv
module sc_crc8_step #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    always_comb begin
        logic [7:0] acc;
        acc = crc_in ^ data_in;
        for (int b = 0; b < 8; b++) begin
            acc = acc[7] ? ((acc << 1) ^ POLY) : (acc << 1);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/sc_gap_timer.sv
module sc_gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         kick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || kick) begin
            cnt_d = '0;
        end else if (cnt_q != limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = run && !kick && (cnt_q == limit);
endmodule

// File: rtl/sc_sat_count.sv
module sc_sat_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != {W{1'b1}})) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/sc_frame_rx.sv
module sc_frame_rx
    import sc_frame_pkg::*;
#(
    parameter int GAP_W = 16,
    parameter int ERR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic [GAP_W-1:0]    gap_limit,
    output logic [7:0]          fw_id,
    output logic [7:0]          cmd_code,
    output logic [DAC_BITS-1:0] dac_set,
    output logic                frame_ok,
    output logic                frame_err,
    output logic [ERR_W-1:0]    crc_fail_count
);
    typedef struct packed {
        rx_state_e           st;
        pos_t                pos;
        logic [7:0]          crc;
        logic [7:0]          fw_sh;
        logic [7:0]          cmd_sh;
        logic [DAC_BITS-1:0] dac_sh;
        logic [7:0]          fw;
        logic [7:0]          cmd;
        logic [DAC_BITS-1:0] dac;
        logic                ok;
        logic                err;
    } rx_regs_t;

    rx_regs_t   r_d, r_q;
    logic [7:0] crc_seed, crc_next;
    logic       gap_expired;

    assign crc_seed = (r_q.st == ST_HUNT) ? 8'h00 : r_q.crc;

    sc_crc8_step #(.POLY(CRC_POLY)) u_crc (
        .crc_in  (crc_seed),
        .data_in (rx_byte),
        .crc_out (crc_next)
    );

    sc_gap_timer #(.W(GAP_W)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .run     (r_q.st != ST_HUNT),
        .kick    (rx_valid),
        .limit   (gap_limit),
        .expired (gap_expired)
    );

    sc_sat_count #(.W(ERR_W)) u_errs (
        .clk   (clk),
        .rst   (rst),
        .inc   (r_d.err),
        .count (crc_fail_count)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ok  = 1'b0;
        r_d.err = 1'b0;
        unique case (r_q.st)
            ST_HUNT: begin
                if (rx_valid && (rx_byte == SOF_BYTE)) begin
                    r_d.st  = ST_TAKE;
                    r_d.pos = pos_t'(1);
                    r_d.crc = crc_next;
                end
            end
            default: begin
                if (gap_expired) begin
                    r_d.st  = ST_HUNT;
                    r_d.pos = '0;
                end else if (rx_valid) begin
                    r_d.pos = r_q.pos + 1'b1;
                    r_d.crc = crc_next;
                    if ((r_q.pos == POS_ADDR) && (rx_byte != MY_ADDR)) r_d.st = ST_PASS;
                    if (r_q.st == ST_TAKE) begin
                        if (r_q.pos == POS_FW)  r_d.fw_sh  = rx_byte;
                        if (r_q.pos == POS_CMD) r_d.cmd_sh = rx_byte;
                        for (int k = 0; k < N_DAC; k++) begin
                            if (r_q.pos == pos_t'(POS_DAC0 + 2*k))
                                r_d.dac_sh[k*DAC_W +: 8] = rx_byte;
                            if (r_q.pos == pos_t'(POS_DAC0 + 2*k + 1))
                                r_d.dac_sh[k*DAC_W + 8 +: 8] = rx_byte;
                        end
                    end
                    if (r_q.pos == POS_LAST) begin
                        r_d.st  = ST_HUNT;
                        r_d.pos = '0;
                        if (r_q.st == ST_TAKE) begin
                            if (r_q.crc == rx_byte) begin
                                r_d.fw  = r_q.fw_sh;
                                r_d.cmd = r_q.cmd_sh;
                                r_d.dac = r_q.dac_sh;
                                r_d.ok  = 1'b1;
                            end else begin
                                r_d.err = 1'b1;
                            end
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign fw_id     = r_q.fw;
    assign cmd_code  = r_q.cmd;
    assign dac_set   = r_q.dac;
    assign frame_ok  = r_q.ok;
    assign frame_err = r_q.err;
endmodule

// File: rtl/sc_frame_rx_chk.sv
module sc_frame_rx_chk #(
    parameter int ERR_W    = 8,
    parameter int DAC_BITS = 80
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          fw_id,
    input logic [7:0]          cmd_code,
    input logic [DAC_BITS-1:0] dac_set,
    input logic                frame_ok,
    input logic                frame_err,
    input logic [ERR_W-1:0]    crc_fail_count
);
    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        !(frame_ok && frame_err));

    assert_ok_single_R9: assert property (@(posedge clk) disable iff (rst)
        frame_ok |=> !frame_ok);

    assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    assert_fields_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !frame_ok |-> ($stable(fw_id) && $stable(cmd_code) && $stable(dac_set)));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> ((crc_fail_count == {ERR_W{1'b1}}) ||
                       (crc_fail_count == ERR_W'($past(crc_fail_count) + 1'b1))));

    assert_count_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (crc_fail_count != $past(crc_fail_count)) |-> frame_err);
endmodule

bind sc_frame_rx sc_frame_rx_chk #(
    .ERR_W    (ERR_W),
    .DAC_BITS (sc_frame_pkg::DAC_BITS)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fw_id          (fw_id),
    .cmd_code       (cmd_code),
    .dac_set        (dac_set),
    .frame_ok       (frame_ok),
    .frame_err      (frame_err),
    .crc_fail_count (crc_fail_count)
);

// File: tb/sim_sc_frame_rx.sv
module sim_sc_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic [15:0] gap_limit = 16'(GAP);
    logic [7:0]  fw_id, cmd_code;
    logic [79:0] dac_set;
    logic        frame_ok, frame_err;
    logic [7:0]  crc_fail_count;

    int total = 0;
    int bad = 0;
    int ok_seen = 0;
    int err_seen = 0;
    bit started = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_frame_rx u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .gap_limit(gap_limit), .fw_id(fw_id), .cmd_code(cmd_code),
        .dac_set(dac_set), .frame_ok(frame_ok), .frame_err(frame_err),
        .crc_fail_count(crc_fail_count)
    );

    function automatic logic [7:0] crc_of(input logic [7:0] b[$], input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            c = c ^ b[i];
            for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    // behavioural reference model
    logic [7:0]  q_frm[$];
    bit          m_in = 0;
    int          m_idle = 0;
    logic [7:0]  m_fw = 0, m_cmd = 0;
    logic [79:0] m_dac = 0;
    bit          m_ok = 0, m_err = 0;
    int          m_cnt = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_in = 0; m_idle = 0; m_fw = 0; m_cmd = 0; m_dac = 0;
            m_ok = 0; m_err = 0; m_cnt = 0; q_frm.delete();
        end else begin
            m_ok = 0; m_err = 0;
            if (!m_in) begin
                if (rx_valid && rx_byte == 8'h40) begin
                    q_frm.delete(); q_frm.push_back(rx_byte); m_in = 1; m_idle = 0;
                end
            end else if (rx_valid) begin
                m_idle = 0;
                q_frm.push_back(rx_byte);
                if (q_frm.size() == 28) begin
                    m_in = 0;
                    if (q_frm[1] == 8'h3F) begin
                        if (crc_of(q_frm, 27) == q_frm[27]) begin
                            m_ok = 1; m_fw = q_frm[3]; m_cmd = q_frm[4];
                            for (int k = 0; k < 5; k++) m_dac[16*k +: 16] = {q_frm[6+2*k], q_frm[5+2*k]};
                        end else begin
                            m_err = 1;
                            if (m_cnt < 255) m_cnt++;
                        end
                    end
                end
            end else if (m_idle == int'(gap_limit)) begin
                m_in = 0;
            end else begin
                m_idle++;
            end
        end
    end

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R6 frame_ok vs model", 80'(frame_ok), 80'(m_ok));
            chk("R7 frame_err vs model", 80'(frame_err), 80'(m_err));
            chk("R4 fw_id vs model", 80'(fw_id), 80'(m_fw));
            chk("R4 cmd_code vs model", 80'(cmd_code), 80'(m_cmd));
            chk("R4 dac_set vs model", dac_set, m_dac);
            chk("R7 crc_fail_count vs model", 80'(crc_fail_count), 80'(m_cnt));
            if (frame_ok) ok_seen++;
            if (frame_err) err_seen++;
        end
    end

    logic [7:0] fr[$];

    function automatic logic [79:0] dac_of(input logic [15:0] base);
        logic [79:0] v;
        for (int k = 0; k < 5; k++) v[16*k +: 16] = base + 16'(k) * 16'h1111;
        return v;
    endfunction

    task automatic make_frame(input logic [7:0] addr, input logic [7:0] src, input logic [7:0] fw,
                              input logic [7:0] cmd, input logic [15:0] base,
                              input logic [7:0] b26, input bit corrupt);
        logic [79:0] v;
        v = dac_of(base);
        fr.delete();
        fr.push_back(8'h40); fr.push_back(addr); fr.push_back(src);
        fr.push_back(fw); fr.push_back(cmd);
        for (int k = 0; k < 5; k++) begin
            fr.push_back(v[16*k +: 8]); fr.push_back(v[16*k+8 +: 8]);
        end
        for (int i = 15; i < 26; i++) fr.push_back(8'h00);
        fr.push_back(b26);
        fr.push_back(crc_of(fr, 27) ^ (corrupt ? 8'h01 : 8'h00));
    endtask

    task automatic send(input logic [7:0] d, input int idle);
        rx_valid = 1'b1; rx_byte = d;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (idle) @(negedge clk);
    endtask

    task automatic send_frame(input int idle, input int gap_pos, input int gap_idle);
        for (int i = 0; i < 28; i++) send(fr[i], (i == gap_pos) ? gap_idle : idle);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset fw_id", 80'(fw_id), 0);
        chk("R1 reset dac_set", dac_set, 0);
        chk("R1 reset count", 80'(crc_fail_count), 0);
        chk("R1 reset pulses", 80'({frame_ok, frame_err}), 0);

        send(8'h00, 1); send(8'hFF, 1); send(8'h3F, 1); send(8'h11, 2);
        chk("R2 junk ignored fw_id", 80'(fw_id), 0);
        chk("R2 junk ignored pulses", 80'(ok_seen + err_seen), 0);

        make_frame(8'h3F, 8'hC0, 8'h11, 8'h22, 16'h1234, 8'h00, 0);
        send_frame(1, -1, 0); repeat (2) @(negedge clk);
        chk("R6 accept pulse", 80'(ok_seen), 1);
        chk("R4 fw_id captured", 80'(fw_id), 80'h11);
        chk("R4 cmd captured", 80'(cmd_code), 80'h22);
        chk("R4 R5 dac captured", dac_set, dac_of(16'h1234));

        make_frame(8'h3F, 8'hC0, 8'h55, 8'h66, 16'h0A0B, 8'h00, 1);
        send_frame(1, -1, 0); repeat (2) @(negedge clk);
        chk("R7 bad crc pulse", 80'(err_seen), 1);
        chk("R7 count one", 80'(crc_fail_count), 1);
        chk("R7 fields kept", 80'(fw_id), 80'h11);

        make_frame(8'h3E, 8'hC0, 8'h77, 8'h01, 16'h0303, 8'h00, 0);
        send_frame(1, -1, 0); repeat (2) @(negedge clk);
        chk("R3 foreign no pulse", 80'(ok_seen + err_seen), 2);
        chk("R3 foreign not captured", 80'(fw_id), 80'h11);
        chk("R3 foreign not counted", 80'(crc_fail_count), 1);

        make_frame(8'h3F, 8'h00, 8'h40, 8'h40, 16'h4040, 8'h7E, 0);
        send_frame(0, -1, 0);
        make_frame(8'h3F, 8'hC0, 8'h21, 8'h31, 16'h0506, 8'h00, 0);
        send_frame(0, -1, 0); repeat (2) @(negedge clk);
        chk("R2 R4 back-to-back frames", 80'(ok_seen), 3);
        chk("R4 second frame fw", 80'(fw_id), 80'h21);

        make_frame(8'h3F, 8'hC0, 8'h91, 8'h92, 16'h2222, 8'h00, 0);
        send_frame(1, 10, GAP); repeat (2) @(negedge clk);
        chk("R8 gap at limit kept", 80'(fw_id), 80'h91);

        make_frame(8'h3F, 8'hC0, 8'hA1, 8'hA2, 16'h0102, 8'h00, 0);
        send_frame(1, 10, GAP + 1); repeat (40) @(negedge clk);
        chk("R8 gap over limit dropped", 80'(fw_id), 80'h91);
        chk("R8 no pulse after drop", 80'(ok_seen + err_seen), 5);

        make_frame(8'h3F, 8'hC0, 8'hB1, 8'hB2, 16'h0708, 8'h00, 0);
        send_frame(1, -1, 0); repeat (2) @(negedge clk);
        chk("R8 recovery frame", 80'(fw_id), 80'hB1);

        make_frame(8'h3F, 8'hC0, 8'h00, 8'h00, 16'h0000, 8'h00, 1);
        for (int n = 0; n < 260; n++) send_frame(0, -1, 0);
        repeat (2) @(negedge clk);
        chk("R7 saturated", 80'(crc_fail_count), 80'd255);
        make_frame(8'h3F, 8'hC0, 8'hC3, 8'hC4, 16'h0909, 8'h00, 0);
        send_frame(1, -1, 0); repeat (2) @(negedge clk);
        chk("R7 stays saturated", 80'(crc_fail_count), 80'd255);
        chk("R6 accept after saturation", 80'(cmd_code), 80'hC4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule